// File: doc/BRIEF.md
# LCD Palette and Frame Load Sequencer

This block sits at the input of a raster LCD controller. It receives a stream of 32-bit words from a DMA source over a valid/ready handshake. A two-bit load-mode input tells it whether the stream carries a colour lookup table only, pixel data only, or a lookup table followed by pixel data. While it loads the table it splits every word into two 16-bit entries and writes the 12-bit colours into a local lookup RAM. It compares the bits-per-pixel code carried in the first entry with the configured mode and sets a status flag when the last table word has been taken.

When the configured mode is 8-bit indexed, the pixel stream that follows is treated as four index bytes per word. Each index reads the lookup RAM, and the resulting RGB444 colour leaves on a valid/ready output stream. Back-pressure propagates from the output to the input. A pixel held with `pix_valid` high and `pix_ready` low stays stable. The input deasserts `in_ready` once the internal word holder cannot make room. Software control is by plain pins: `enable` starts a load sequence and aborts one, and `stat_clr` is a clear pulse for the loaded flag.

Top module: `lcd_load_seq`

## Requirements
- R1: `load_mode` is sampled on the first enabled cycle after a disabled one. 2'b01 = table only, 2'b10 = pixels only (no table, `pal_loaded` stays 0), 2'b00 = table then pixels, 2'b11 = reserved, and then no word is ever accepted.
- R2: The table holds 16 entries when `bpp_mode` is 4 and 256 entries for any other code. A load takes entries/2+1 words (9 or 129). Each word gives two entries, bits 15:0 first. Entries past the table size are dropped.
- R3: Entry k is written to RAM index k with colour bits 11:0 (red 11:8, green 7:4, blue 3:0). Bits 15:12 of an entry are not stored.
- R4: Bits 14:12 of entry 0 are the header code (0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, 4 = 12/16 bpp). If the code differs from `bpp_mode`, `pal_err` is set and stays set until disable, and the table is still written in full.
- R5: `pal_loaded` rises in the cycle after the last table word is accepted and not earlier.
- R6: In table-only mode `stat_clr` clears `pal_loaded`. In the other modes `stat_clr` has no effect. Disable clears it in every mode.
- R7: After a table-only load completes, `in_ready` stays low until disable.
- R8: In the pixel phase with `bpp_mode` = 3, each word yields four indices, byte 7:0 first. Each index produces `pix_rgb` = RAM[index] with `pix_valid` one cycle after the index is issued.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_rgb` holds. No pixel is lost or repeated under any stall pattern.
- R10: In the pixel phase with `bpp_mode` other than 3, words are accepted and discarded, and no pixel is produced.
- R11: With `enable` low, `in_ready`, `pix_valid`, `pal_loaded` and `pal_err` are all 0 one cycle later. Reset gives the same state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs a load sequence; low aborts and clears status |
| load_mode | input | 2 | Stream content selector |
| bpp_mode | input | 3 | Configured bits-per-pixel code |
| stat_clr | input | 1 | Clear pulse for the loaded flag (table-only mode) |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input word |
| pix_valid | output | 1 | Output colour valid |
| pix_ready | input | 1 | Downstream can take a colour |
| pix_rgb | output | 12 | RGB444 colour |
| pal_loaded | output | 1 | Table load complete flag |
| pal_err | output | 1 | Header code mismatch flag |

## Verification
The hardest case to reach is the dropping of the trailing entries beyond a 16-entry table. The pixel path does not run in that mode, so the dropped entries can only be seen in a later run. The stimulus loads a 16-entry table, restarts in pixel-only 8-bit mode, and issues indices 0 to 17 directly, so that entries 16 and 17 must still show the older colours. Irregular `pix_ready` stalls drawn from a seeded generator run in the same frames, which makes the last-byte refill path of the word holder meet a held output.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    LM_PAL_FRAME  = 2'b00,
    LM_PAL_ONLY   = 2'b01,
    LM_FRAME_ONLY = 2'b10,
    LM_RESERVED   = 2'b11
  } load_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PAL,
    ST_FRAME,
    ST_HALT
  } seq_state_e;

  localparam logic [2:0] BPP_CODE_8  = 3'd3;
  localparam logic [2:0] BPP_CODE_16 = 3'd4;
endpackage

// File: rtl/lcd_pal_ram.sv
module lcd_pal_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] din_a,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] din_b,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  // Two write ports: one per half of an input word (addresses never collide).
  always_ff @(posedge clk) begin
    if (we_a) mem[addr_a] <= din_a;
    if (we_b) mem[addr_b] <= din_b;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/lcd_pal_writer.sv
module lcd_pal_writer
  import lcd_seq_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int SMALL   = 16,
  parameter int DW      = 12,
  localparam int AW     = $clog2(DEPTH),
  localparam int WCW    = $clog2(DEPTH / 2 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          fire,
  input  logic [31:0]   data,
  input  logic [2:0]    bpp_code,
  output logic          we_lo,
  output logic          we_hi,
  output logic [AW-1:0] addr_lo,
  output logic [AW-1:0] addr_hi,
  output logic [DW-1:0] din_lo,
  output logic [DW-1:0] din_hi,
  output logic          done,
  output logic          mismatch
);
  logic [WCW-1:0] wcnt;
  logic [WCW-1:0] last_w;
  logic [AW:0]    limit;
  logic [AW:0]    lo_idx;
  logic           unused_bits;

  assign limit   = (bpp_code == BPP_CODE_16) ? (AW+1)'(SMALL) : (AW+1)'(DEPTH);
  assign last_w  = WCW'(limit >> 1);
  assign lo_idx  = (AW+1)'(wcnt) << 1;

  assign we_lo   = fire && (lo_idx < limit);
  assign we_hi   = fire && ((lo_idx + 1'b1) < limit);
  assign addr_lo = lo_idx[AW-1:0];
  assign addr_hi = {lo_idx[AW-1:1], 1'b1};
  assign din_lo  = data[DW-1:0];
  assign din_hi  = data[16 +: DW];

  assign done     = fire && (wcnt == last_w);
  assign mismatch = fire && (wcnt == '0) && (data[14:12] != bpp_code);

  assign unused_bits = ^{data[31:28], data[15]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wcnt <= '0;
    else if (clear)          wcnt <= '0;
    else if (fire && !done)  wcnt <= wcnt + 1'b1;
  end
endmodule

// File: rtl/lcd_pix_expand.sv
module lcd_pix_expand #(
  parameter int WORD_W  = 32,
  parameter int PIX_W   = 8,
  parameter int DW      = 12,
  localparam int PER_WORD = WORD_W / PIX_W,
  localparam int IW       = $clog2(PER_WORD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              rd_en,
  output logic [PIX_W-1:0]  rd_addr,
  input  logic [DW-1:0]     rd_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [DW-1:0]     pix_rgb
);
  logic [WORD_W-1:0] hold_q;
  logic              hold_v;
  logic [IW-1:0]     idx;
  logic              adv;
  logic              issue;
  logic              load;
  logic              last_byte;

  assign adv       = !pix_valid || pix_ready;
  assign issue     = hold_v && adv;
  assign last_byte = (idx == IW'(PER_WORD - 1));
  assign in_ready  = !hold_v || (last_byte && adv);
  assign load      = en && in_valid && in_ready;

  assign rd_en   = issue;
  assign rd_addr = hold_q[int'(idx) * PIX_W +: PIX_W];
  assign pix_rgb = rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
      idx    <= '0;
    end else if (flush) begin
      hold_v <= 1'b0;
      idx    <= '0;
    end else if (load) begin
      hold_q <= in_data;
      hold_v <= 1'b1;
      idx    <= '0;
    end else if (issue) begin
      idx <= idx + 1'b1;
      if (last_byte) hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pix_valid <= 1'b0;
    else if (flush) pix_valid <= 1'b0;
    else if (adv)   pix_valid <= issue;
  end
endmodule

// File: rtl/lcd_load_seq.sv
module lcd_load_seq
  import lcd_seq_pkg::*;
#(
  parameter int PAL_DEPTH = 256,
  parameter int PAL_SMALL = 16,
  parameter int COLOR_W   = 12,
  parameter int WORD_W    = 32,
  localparam int AW       = $clog2(PAL_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [1:0]         load_mode,
  input  logic [2:0]         bpp_mode,
  input  logic               stat_clr,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_data,
  output logic               pix_valid,
  input  logic               pix_ready,
  output logic [COLOR_W-1:0] pix_rgb,
  output logic               pal_loaded,
  output logic               pal_err
);
  seq_state_e state;
  load_mode_e mode_q;

  logic               lut_mode;
  logic               xp_ready;
  logic               pal_fire;
  logic               pal_done;
  logic               pal_mism;
  logic               we_lo, we_hi;
  logic [AW-1:0]      addr_lo, addr_hi;
  logic [COLOR_W-1:0] din_lo, din_hi;
  logic               rd_en;
  logic [AW-1:0]      rd_addr;
  logic [COLOR_W-1:0] rd_data;

  assign lut_mode = (bpp_mode == BPP_CODE_8);

  always_comb begin
    in_ready = 1'b0;
    if (enable) begin
      case (state)
        ST_PAL:   in_ready = 1'b1;
        ST_FRAME: in_ready = lut_mode ? xp_ready : 1'b1;
        default:  in_ready = 1'b0;
      endcase
    end
  end

  assign pal_fire = in_valid && in_ready && (state == ST_PAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mode_q     <= LM_PAL_FRAME;
      pal_loaded <= 1'b0;
      pal_err    <= 1'b0;
    end else if (!enable) begin
      state      <= ST_IDLE;
      pal_loaded <= 1'b0;
      pal_err    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          mode_q <= load_mode_e'(load_mode);
          case (load_mode_e'(load_mode))
            LM_PAL_FRAME, LM_PAL_ONLY: state <= ST_PAL;
            LM_FRAME_ONLY:             state <= ST_FRAME;
            default:                   state <= ST_HALT;
          endcase
        end
        ST_PAL:
          if (pal_done) state <= (mode_q == LM_PAL_ONLY) ? ST_HALT : ST_FRAME;
        default: ;
      endcase
      if (pal_done)                                pal_loaded <= 1'b1;
      else if (stat_clr && mode_q == LM_PAL_ONLY)  pal_loaded <= 1'b0;
      if (pal_mism) pal_err <= 1'b1;
    end
  end

  lcd_pal_writer #(
    .DEPTH (PAL_DEPTH),
    .SMALL (PAL_SMALL),
    .DW    (COLOR_W)
  ) u_writer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (state == ST_IDLE),
    .fire     (pal_fire),
    .data     (in_data),
    .bpp_code (bpp_mode),
    .we_lo    (we_lo),
    .we_hi    (we_hi),
    .addr_lo  (addr_lo),
    .addr_hi  (addr_hi),
    .din_lo   (din_lo),
    .din_hi   (din_hi),
    .done     (pal_done),
    .mismatch (pal_mism)
  );

  lcd_pal_ram #(
    .DEPTH (PAL_DEPTH),
    .DW    (COLOR_W)
  ) u_ram (
    .clk     (clk),
    .we_a    (we_lo),
    .addr_a  (addr_lo),
    .din_a   (din_lo),
    .we_b    (we_hi),
    .addr_b  (addr_hi),
    .din_b   (din_hi),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  lcd_pix_expand #(
    .WORD_W (WORD_W),
    .PIX_W  (AW),
    .DW     (COLOR_W)
  ) u_expand (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!enable),
    .en        (enable && state == ST_FRAME && lut_mode),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (xp_ready),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_rgb   (pix_rgb)
  );
endmodule

// File: rtl/lcd_load_seq_chk.sv
module lcd_load_seq_chk
  import lcd_seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        stat_clr,
  input logic        in_ready,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic [11:0] pix_rgb,
  input logic        pal_loaded,
  input logic        pal_err,
  input seq_state_e  state,
  input load_mode_e  mode_q
);
  // R9: a stalled colour stays put
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enable && pix_valid && !pix_ready |=> pix_valid && $stable(pix_rgb));

  // R11: disable clears the interface and status
  p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !in_ready && !pix_valid && !pal_loaded && !pal_err);

  // R6: outside table-only mode the flag survives until disable
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enable && pal_loaded && mode_q != LM_PAL_ONLY |=> pal_loaded);

  // R6: clear pulse works in table-only mode after completion
  p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enable && stat_clr && mode_q == LM_PAL_ONLY && state == ST_HALT |=> !pal_loaded);

  // R7: table-only completion closes the input
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pal_loaded) && mode_q == LM_PAL_ONLY |-> !in_ready);

  // R4: a mismatch can only come from the table phase
  p_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pal_err) |-> $past(state) == ST_PAL);

  // R1: pixel-only runs never report a loaded table
  p_frame_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    enable && state == ST_FRAME && mode_q == LM_FRAME_ONLY |-> !pal_loaded);
endmodule

bind lcd_load_seq lcd_load_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .stat_clr   (stat_clr),
  .in_ready   (in_ready),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .pix_rgb    (pix_rgb),
  .pal_loaded (pal_loaded),
  .pal_err    (pal_err),
  .state      (state),
  .mode_q     (mode_q)
);

// File: tb/lcd_load_seq_test.sv
module lcd_load_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  load_mode = 2'b00;
  logic [2:0]  bpp_mode = 3'd3;
  logic        stat_clr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        pix_valid;
  logic        pix_ready = 1'b1;
  logic [11:0] pix_rgb;
  logic        pal_loaded;
  logic        pal_err;

  int checks = 0;
  int fails = 0;
  bit rand_ready = 1'b0;
  bit done = 1'b0;
  logic [11:0] model [256];
  logic [7:0]  exp_q [$];
  logic [11:0] got_q [$];

  always #5 clk = ~clk;

  lcd_load_seq uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load_mode(load_mode),
    .bpp_mode(bpp_mode), .stat_clr(stat_clr), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_rgb(pix_rgb), .pal_loaded(pal_loaded),
    .pal_err(pal_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Output sink: choose ready for the coming edge, then log a transfer.
  always @(negedge clk) begin
    pix_ready = rand_ready ? (($urandom % 3) != 0) : 1'b1;
    if (rst_n && pix_valid && pix_ready) got_q.push_back(pix_rgb);
  end

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic start(input logic [1:0] m, input logic [2:0] b);
    @(negedge clk);
    load_mode = m;
    bpp_mode  = b;
    enable    = 1'b1;
  endtask

  task automatic stop();
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 in_ready off", in_ready, 0);
    chk("R11 pix_valid off", pix_valid, 0);
    chk("R6 R11 loaded cleared by disable", pal_loaded, 0);
    chk("R11 err cleared", pal_err, 0);
  endtask

  // Table load: nent entries kept, hdr in entry 0 bits 14:12.
  task automatic load_table(input int nent, input logic [2:0] hdr);
    int nw = nent / 2 + 1;
    for (int w = 0; w < nw; w++) begin
      logic [15:0] lo = 16'($urandom);
      logic [15:0] hi = 16'($urandom);
      if (w == 0) lo[14:12] = hdr;
      if (2 * w < nent)     model[2 * w]     = lo[11:0];
      if (2 * w + 1 < nent) model[2 * w + 1] = hi[11:0];
      send({hi, lo});
      if (w == nw - 2) chk("R5 R2 not loaded before last word", pal_loaded, 0);
    end
    @(negedge clk);
    chk("R5 R2 loaded after last word", pal_loaded, 1);
  endtask

  task automatic frame_words(input logic [31:0] ws [$]);
    exp_q.delete();
    got_q.delete();
    foreach (ws[i]) begin
      for (int k = 0; k < 4; k++) exp_q.push_back(ws[i][8 * k +: 8]);
      send(ws[i]);
    end
    for (int t = 0; t < 4000 && got_q.size() < exp_q.size(); t++) @(negedge clk);
    chk("R9 pixel count", got_q.size(), exp_q.size());
    foreach (exp_q[i])
      if (i < got_q.size()) chk("R8 R3 lookup colour", got_q[i], model[exp_q[i]]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] ws [$];
    void'($urandom(32'd4242));
    foreach (model[i]) model[i] = 12'h000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset in_ready", in_ready, 0);
    chk("R11 reset pix_valid", pix_valid, 0);
    chk("R5 reset loaded", pal_loaded, 0);
    chk("R4 reset err", pal_err, 0);

    // Table then pixels, 8 bpp, matching header, stalls on output
    start(2'b00, 3'd3);
    load_table(256, 3'd3);
    chk("R4 no mismatch", pal_err, 0);
    rand_ready = 1'b1;
    ws.delete();
    for (int i = 0; i < 24; i++) ws.push_back($urandom);
    frame_words(ws);
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    chk("R6 clear ignored outside table-only", pal_loaded, 1);
    stop();

    // Table only with a wrong header code
    start(2'b01, 3'd3);
    load_table(256, 3'd4);
    chk("R4 mismatch flagged", pal_err, 1);
    in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R7 input closed after table-only", in_ready, 0);
    end
    in_valid = 1'b0;
    stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    chk("R6 clear in table-only", pal_loaded, 0);
    chk("R4 err sticky", pal_err, 1);
    stop();

    // Pixel only: mismatching table was still written
    rand_ready = 1'b0;
    start(2'b10, 3'd3);
    ws.delete();
    for (int i = 0; i < 16; i++) ws.push_back($urandom);
    frame_words(ws);
    chk("R1 pixel-only leaves loaded low", pal_loaded, 0);
    stop();

    // 16-entry table, then discarded pixel words
    start(2'b00, 3'd4);
    load_table(16, 3'd4);
    chk("R4 code 4 matches", pal_err, 0);
    got_q.delete();
    for (int i = 0; i < 5; i++) send($urandom);
    repeat (6) @(negedge clk);
    chk("R10 no pixels outside 8 bpp", got_q.size(), 0);
    stop();

    // Indices 0..17 show new 0..15 and untouched 16, 17
    rand_ready = 1'b1;
    start(2'b10, 3'd3);
    ws.delete();
    for (int i = 0; i < 18; i += 4)
      ws.push_back({8'(i + 3), 8'(i + 2), 8'(i + 1), 8'(i)});
    ws.push_back(32'hFF00_FF00);
    for (int i = 0; i < 10; i++) ws.push_back($urandom);
    frame_words(ws);
    stop();

    // Reserved mode accepts nothing
    start(2'b11, 3'd3);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reserved mode closed", in_ready, 0);
    in_valid = 1'b0;
    stop();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule